// File: doc/BRIEF.md
# Programmable External Wait-State Generator

This block stretches external bus accesses by a programmable number of clock cycles. When an access starts, the block looks at the access space and the address. The space is program, data or I/O. From these it picks a 3-bit base wait count out of a software-writable select register. If the doubling bit in a separate control register is set, the base count is multiplied by two. The block then holds its ready output low for that many cycles. After that it pulses ready high for one cycle to end the access.

Software reaches both registers through a small synchronous port with an address, a write enable, write data and combinational read data. The count that applies to an access is captured when the access is accepted. Later register writes therefore change only the accesses that follow. An extended-program mode lets a single field govern the whole program space, including addresses above 64K words.

Top module: `xwait_gen`

## Requirements
- R1: After reset the select register reads 16'h1249, so every 3-bit count field holds 1 and bit 15 holds 0. The control register reads 0, ready is low and wait_cur is 0.
- R2: A write at SEL_ADDR (default 8'h40) stores all 16 bits of the select register and reads back unchanged. A read at any address other than SEL_ADDR or CTL_ADDR returns 0.
- R3: At CTL_ADDR (default 8'h41) only bit 0, the doubling bit, is writable. Bits 15:1 always read 0.
- R4: An access with acc_space=2 (I/O) uses select bits 14:12 at every address.
- R5: An access with acc_space=1 (data) uses bits 8:6 when acc_addr[15]=0 and bits 11:9 when acc_addr[15]=1.
- R6: An access with acc_space=0 (program) while select bit 15 is 0 uses bits 2:0 when acc_addr[15]=0 and bits 5:3 when acc_addr[15]=1. Address bits 19:16 make no difference.
- R7: While select bit 15 is 1, program accesses use bits 2:0 at every address, and bits 5:3 have no effect. acc_space=3 selects no wait states.
- R8: With the doubling bit set, the effective count is twice the base count, 14 at most. With the bit clear, the base count is used unchanged.
- R9: An accepted strobe with effective count N>0 holds ready low for N cycles, counting the strobe cycle. Ready is then high for exactly one cycle. With N=0, ready is high in the strobe cycle itself.
- R10: A strobe that arrives while an access is in progress, including its ready cycle, is ignored. Neither ready timing nor wait_cur changes.
- R11: A register write made during an access, or in the same cycle as its strobe, does not change that access. It applies from the next accepted strobe.
- R12: From the cycle after a strobe is accepted, wait_cur shows that access's effective count. It holds that value until the next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW (8) | Register port address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| acc_start | input | 1 | Access-start strobe |
| acc_space | input | 2 | Access space: 0 program, 1 data, 2 I/O, 3 none |
| acc_addr | input | ADDR_W (20) | Access address; bits above 15 matter only for program space |
| ready | output | 1 | One-cycle pulse ending the access |
| wait_cur | output | 4 | Effective wait count of the latest accepted access |

## Verification
The assertions assume that acc_start is a single-cycle request and that a strobe during a busy access is simply dropped. They also assume the register port never writes both registers in one cycle, which the distinct addresses guarantee. The bench lowers acc_start again the cycle after each strobe. It raises stray strobes only inside a running access, where they must be ignored. Random register values and random 20-bit addresses in all four space codes are mixed with directed cases. These cover a count of 0, doubled 7, extended program mode at high addresses, and register writes that race a strobe.

// File: rtl/xwait_pkg.sv
package xwait_pkg;

  localparam int FW      = 3;        // width of one count field
  localparam int NFIELD  = 5;        // count fields in the select register
  localparam int DW      = 16;       // register width
  localparam int CW      = FW + 1;   // effective count width after doubling

  localparam int F_PLO   = 0;        // program, low half (or all in extended mode)
  localparam int F_PHI   = 1;        // program, high half
  localparam int F_DLO   = 2;        // data, low half
  localparam int F_DHI   = 3;        // data, high half
  localparam int F_IO    = 4;        // I/O space
  localparam int XPROG_B = 15;       // extended-program mode bit

  typedef enum logic [1:0] {
    SPC_PROG = 2'd0,
    SPC_DATA = 2'd1,
    SPC_IO   = 2'd2,
    SPC_NONE = 2'd3
  } space_e;

  function automatic logic [DW-1:0] sel_reset();
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NFIELD; i++) v[i*FW] = 1'b1;
    return v;
  endfunction

  function automatic logic [FW-1:0] field(input logic [DW-1:0] sel, input int idx);
    return sel[idx*FW +: FW];
  endfunction

  function automatic logic [FW-1:0] base_wait(input logic [DW-1:0] sel,
                                              input space_e sp,
                                              input logic hi);
    case (sp)
      SPC_PROG: base_wait = (sel[XPROG_B] || !hi) ? field(sel, F_PLO) : field(sel, F_PHI);
      SPC_DATA: base_wait = hi ? field(sel, F_DHI) : field(sel, F_DLO);
      SPC_IO:   base_wait = field(sel, F_IO);
      default:  base_wait = '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] scale_wait(input logic [FW-1:0] base, input logic dbl);
    return dbl ? {base, 1'b0} : {1'b0, base};
  endfunction

endpackage

// File: rtl/xwait_regs.sv
module xwait_regs
  import xwait_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] SEL_ADDR = 8'h40,
  parameter logic [REG_AW-1:0] CTL_ADDR = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [DW-1:0]     sel_q,
  output logic              dbl_q
);

  localparam logic [DW-1:0] SEL_RST = sel_reset();

  logic sel_hit, ctl_hit, sel_wr, ctl_wr;
  assign sel_hit = (reg_addr == SEL_ADDR);
  assign ctl_hit = (reg_addr == CTL_ADDR);
  assign sel_wr  = reg_we && sel_hit;
  assign ctl_wr  = reg_we && ctl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
      dbl_q <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= reg_wdata;
      if (ctl_wr) dbl_q <= reg_wdata[0];
    end
  end

  always_comb begin
    if (sel_hit)      reg_rdata = sel_q;
    else if (ctl_hit) reg_rdata = {{(DW-1){1'b0}}, dbl_q};
    else              reg_rdata = '0;
  end

  // R2
  sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(reg_wdata)));

  // R3
  ctl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |-> (reg_rdata[DW-1:1] == '0));

endmodule

// File: rtl/xwait_select.sv
module xwait_select
  import xwait_pkg::*;
(
  input  logic [DW-1:0] sel_q,
  input  logic          dbl_q,
  input  logic [1:0]    acc_space,
  input  logic          addr_hi,
  output logic [CW-1:0] eff_wait
);

  logic [FW-1:0] base;

  always_comb begin
    base     = base_wait(sel_q, space_e'(acc_space), addr_hi);
    eff_wait = scale_wait(base, dbl_q);
  end

endmodule

// File: rtl/xwait_timer.sv
module xwait_timer
  import xwait_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start,
  input  logic [CW-1:0] eff_wait,
  output logic          ready,
  output logic [CW-1:0] wait_cur
);

  localparam logic [CW-1:0] MAX_WAIT = CW'(((1 << FW) - 1) * 2);

  logic          busy;
  logic [CW-1:0] rem;
  logic          accept, finish, zero_wait;

  assign accept    = acc_start && !busy;
  assign zero_wait = (eff_wait == '0);
  assign finish    = busy && (rem == '0);
  assign ready     = (accept && zero_wait) || finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rem      <= '0;
      wait_cur <= '0;
    end else if (accept) begin
      busy     <= !zero_wait;
      rem      <= zero_wait ? '0 : eff_wait - CW'(1);
      wait_cur <= eff_wait;
    end else if (finish) begin
      busy     <= 1'b0;
    end else if (busy) begin
      rem      <= rem - CW'(1);
    end
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && rem == $past(rem) - CW'(1)));

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wait_cur));

  // R8
  rem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < MAX_WAIT));

endmodule

// File: rtl/xwait_gen.sv
module xwait_gen
  import xwait_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 20,
  parameter logic [REG_AW-1:0] SEL_ADDR = 8'h40,
  parameter logic [REG_AW-1:0] CTL_ADDR = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              acc_start,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ready,
  output logic [3:0]        wait_cur
);

  logic [DW-1:0] sel_q;
  logic          dbl_q;
  logic [CW-1:0] eff_wait;

  generate
    if (ADDR_W > 16) begin : g_ext
      logic unused_addr;
      assign unused_addr = ^{acc_addr[ADDR_W-1:16], acc_addr[14:0]};
    end else begin : g_flat
      logic unused_addr;
      assign unused_addr = ^acc_addr[14:0];
    end
  endgenerate

  xwait_regs #(
    .REG_AW   (REG_AW),
    .SEL_ADDR (SEL_ADDR),
    .CTL_ADDR (CTL_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sel_q     (sel_q),
    .dbl_q     (dbl_q)
  );

  xwait_select u_sel (
    .sel_q     (sel_q),
    .dbl_q     (dbl_q),
    .acc_space (acc_space),
    .addr_hi   (acc_addr[15]),
    .eff_wait  (eff_wait)
  );

  xwait_timer u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .eff_wait  (eff_wait),
    .ready     (ready),
    .wait_cur  (wait_cur)
  );

endmodule

// File: tb/sim_xwait_gen.sv
module sim_xwait_gen;

  localparam logic [7:0] SEL_A = 8'h40;
  localparam logic [7:0] CTL_A = 8'h41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_start = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [19:0] acc_addr = '0;
  logic        ready;
  logic [3:0]  wait_cur;

  int checks = 0;
  int fails  = 0;
  int sel_m  = 16'h1249;
  int mul_m  = 0;

  always #5 clk = ~clk;

  xwait_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_start(acc_start),
    .acc_space(acc_space), .acc_addr(acc_addr), .ready(ready), .wait_cur(wait_cur)
  );

  function automatic int exp_wait(input int s, input int sp, input int a, input int m);
    int b;
    int hi;
    hi = (a >> 15) & 1;
    case (sp)
      0: b = (((s >> 15) & 1) == 1 || hi == 0) ? (s & 7) : ((s >> 3) & 7);
      1: b = (hi == 1) ? ((s >> 9) & 7) : ((s >> 6) & 7);
      2: b = (s >> 12) & 7;
      default: b = 0;
    endcase
    return (m != 0) ? b * 2 : b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
    if (a == SEL_A) sel_m = d & 16'hFFFF;
    if (a == CTL_A) mul_m = d & 1;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a; #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  // poke: stray strobes while busy (R10); midwr: register write mid-access (R11)
  task automatic access(input int sp, input int a, input string tag,
                        input bit poke, input bit midwr);
    int n;
    n = exp_wait(sel_m, sp, a, mul_m);
    @(negedge clk);
    acc_start = 1'b1; acc_space = 2'(sp); acc_addr = 20'(a); #1;
    chk({tag, " R9 strobe-cycle ready"}, int'(ready), (n == 0) ? 1 : 0);
    @(negedge clk);
    acc_start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      reg_we = 1'b0;
      #1;
      chk({tag, " R9 ready timing"}, int'(ready), (k == n) ? 1 : 0);
      if (k == 1) chk({tag, " R12 wait_cur"}, int'(wait_cur), n);
      if (poke) begin
        acc_start = 1'b1; acc_space = 2'(($urandom % 3)); acc_addr = 20'($urandom);
      end
      if (midwr && k == 1) begin
        reg_addr = SEL_A; reg_we = 1'b1; reg_wdata = 16'($urandom);
        sel_m = int'(reg_wdata);
      end
      @(negedge clk);
    end
    acc_start = 1'b0; reg_we = 1'b0; #1;
    chk({tag, " R9 idle after"}, int'(ready), 0);
    chk({tag, " R12 wait_cur held"}, int'(wait_cur), n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 ready", int'(ready), 0);
    chk("R1 wait_cur", int'(wait_cur), 0);
    rd(SEL_A, 16'h1249, "R1 select reset");
    rd(CTL_A, 0, "R1 control reset");

    // R2 / R3 register port
    wr(SEL_A, 16'hA5C3);
    rd(SEL_A, 16'hA5C3, "R2 select readback");
    rd(8'h42, 0, "R2 unmapped read");
    wr(CTL_A, 16'hFFFF);
    rd(CTL_A, 1, "R3 control readback");
    wr(CTL_A, 16'hFFFE);
    rd(CTL_A, 0, "R3 control bit0 clear");

    // R4..R7 decode, directed; fields 7,6,5,4,3 from high to low
    wr(SEL_A, (7 << 12) | (6 << 9) | (5 << 6) | (4 << 3) | 3);
    access(2, 20'h00000, "R4 io low", 0, 0);
    access(2, 20'hFFFFF, "R4 io high", 0, 0);
    access(1, 20'h07FFF, "R5 data low", 0, 0);
    access(1, 20'h08000, "R5 data high", 0, 0);
    access(0, 20'h17FFF, "R6 prog low ext", 0, 0);
    access(0, 20'hF8000, "R6 prog high", 0, 0);
    wr(SEL_A, 16'h8000 | (7 << 12) | (4 << 3) | 2);
    access(0, 20'hF8000, "R7 xprog high", 0, 0);
    access(0, 20'h00010, "R7 xprog low", 0, 0);
    access(3, 20'h08000, "R7 no space", 0, 0);

    // R8 doubling, including max 14 and zero
    wr(CTL_A, 1);
    access(2, 20'h01234, "R8 doubled max", 0, 0);
    wr(SEL_A, 0);
    access(1, 20'h0C000, "R8 doubled zero", 0, 0);
    wr(CTL_A, 0);
    access(1, 20'h0C000, "R9 zero wait", 0, 0);

    // R10 stray strobes while busy
    wr(SEL_A, 16'h5555);
    access(2, 20'h00000, "R10 stray strobes", 1, 0);

    // R11 write during access
    wr(SEL_A, 6 << 12);
    access(2, 20'h00000, "R11 mid write", 0, 1);
    rd(SEL_A, sel_m, "R11 mid write landed");

    // R11 write in the same cycle as the strobe: old count applies
    wr(SEL_A, 3 << 12);
    @(negedge clk);
    reg_addr = SEL_A; reg_we = 1'b1; reg_wdata = 16'(7 << 12);
    acc_start = 1'b1; acc_space = 2'd2; acc_addr = '0;
    @(negedge clk);
    reg_we = 1'b0; acc_start = 1'b0; #1;
    chk("R11 same-cycle wait_cur", int'(wait_cur), 3);
    sel_m = 7 << 12;
    repeat (3) @(negedge clk);
    access(2, 20'h00000, "R11 next access", 0, 0);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 6);
      if (r == 0) wr(SEL_A, int'($urandom & 16'hFFFF));
      else if (r == 1) wr(CTL_A, int'($urandom & 16'hFFFF));
      else if (r == 2) rd(SEL_A, sel_m, "R2 random readback");
      else access(int'($urandom % 4), int'($urandom & 20'hFFFFF), "R4-8 random", (i % 7) == 0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule